// File: doc/BRIEF.md
# Channel Command Flag and Suppress Control

This block holds the five modifier flags that a selector-style I/O channel takes from the second half of a channel command word. The flag field is captured when the second command-word half is processed. The same cycle applies the rule that data chaining cancels command chaining and length suppression. An interface check can later withdraw command chaining. Operations that write with data chaining do not reload the flags.

Beside the flags, the block keeps two control latches. Suppress-out has three independent set causes and two clear events. Service-out hold is raised when a unit answers selection with status, unless the control unit reports busy. It stays up until storage signals that the data fetch is done. When a set and a clear hit the same latch in one cycle, the clear wins.

Top module: `ccw_flag_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, all five flags, suppress-out and service-out hold read 0.
- R2: An accepted load copies the flag field into the flags, visible in the next cycle. The field bits are bit 4 chain data, bit 3 chain command, bit 2 length-suppress, bit 1 skip and bit 0 program interrupt. A load is accepted when ccw2_load_i is 1, unless dir_write_i and wr_dchain_i are both 1.
- R3: When an accepted load carries bit 4 = 1, chain command and length-suppress are stored as 0 in that same load, so the raw conflicting value never appears at the outputs.
- R4: A load with dir_write_i = 1 and wr_dchain_i = 1 leaves all five flags unchanged.
- R5: if_check_i = 1 clears chain command in the next cycle, also on a load cycle. The other four flags are not affected.
- R6: chan_end_i = 1 while flag_cc_o = 1 sets suppress-out in the next cycle.
- R7: An accepted load with dir_write_i = 0 and bit 4 = 1 sets suppress-out in the next cycle.
- R8: dir_write_i = 1 with wr_reg_full_i = 1 and rec_end_i = 0 sets suppress-out in the next cycle.
- R9: unit_sel_i = 1 or bytecnt_load_i = 1 clears suppress-out in the next cycle, even when a set cause is present in the same cycle. Otherwise suppress-out keeps its value.
- R10: A unit_sel_i pulse opens selection, and the first later cycle with status_in_i = 1 closes it. If that closing status has cu_busy_i = 0, service-out hold is set in the next cycle.
- R11: Closing status with cu_busy_i = 1 does not set service-out hold. Status outside a selection also has no effect on it.
- R12: fetch_done_i = 1 clears service-out hold in the next cycle, taking priority over a set in the same cycle. Otherwise the hold keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ccw_flags_i | input | 5 | Flag field of the second command-word half |
| ccw2_load_i | input | 1 | Flag load strobe |
| dir_write_i | input | 1 | 1 = write operation, 0 = read |
| wr_dchain_i | input | 1 | Write data chaining in progress |
| if_check_i | input | 1 | Interface check suppresses command chaining |
| chan_end_i | input | 1 | Channel-end status received |
| bytecnt_load_i | input | 1 | Byte counter loaded with new count |
| unit_sel_i | input | 1 | Unit selection starts |
| status_in_i | input | 1 | Status-in from the unit |
| cu_busy_i | input | 1 | Status is a control-unit-busy response |
| wr_reg_full_i | input | 1 | Write data register full |
| rec_end_i | input | 1 | End of record reached |
| fetch_done_i | input | 1 | Storage fetch of data complete |
| flag_cda_o | output | 1 | Chain data flag |
| flag_cc_o | output | 1 | Chain command flag |
| flag_sili_o | output | 1 | Length-suppress flag |
| flag_skip_o | output | 1 | Skip flag |
| flag_pci_o | output | 1 | Program interrupt flag |
| sup_out_o | output | 1 | Suppress-out latch |
| svc_hold_o | output | 1 | Service-out hold latch |

## Verification
The bench builds the block with CLEAR_WINS = 1. This is the priority the requirements call for: a clear beats a set in the same cycle on both latches. The random mix makes set and clear events collide often, so that priority is tested many times per run rather than only in the directed cases. The random loads cover all 32 flag field values, in both directions and with and without write data chaining.

// File: rtl/ccw_flag_pkg.sv
package ccw_flag_pkg;
  localparam int FLAG_W = 5;

  typedef struct packed {
    logic cda;
    logic cc;
    logic sili;
    logic skip;
    logic pci;
  } ccw_flags_t;

  // Data chaining overrides command chaining and length suppression
  function automatic ccw_flags_t fold_cda(input ccw_flags_t raw);
    ccw_flags_t r;
    r = raw;
    if (raw.cda) begin
      r.cc   = 1'b0;
      r.sili = 1'b0;
    end
    return r;
  endfunction

  // Next value of a set/clear latch with a selectable priority
  function automatic logic latch_next(input logic cur, input logic set,
                                      input logic clr, input logic clr_wins);
    logic n;
    if (clr_wins) n = clr ? 1'b0 : (set ? 1'b1 : cur);
    else          n = set ? 1'b1 : (clr ? 1'b0 : cur);
    return n;
  endfunction
endpackage

// File: rtl/ccw_flag_reg.sv
module ccw_flag_reg
  import ccw_flag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [FLAG_W-1:0]    flags_raw,
  input  logic                 load,
  input  logic                 dir_write,
  input  logic                 wr_dchain,
  input  logic                 if_check,
  output ccw_flags_t           flags_q,
  output logic                 load_ok
);
  ccw_flags_t flags_d;
  logic       load_blocked;

  assign load_blocked = load && dir_write && wr_dchain;
  assign load_ok      = load && !load_blocked;

  always_comb begin
    flags_d = flags_q;
    if (load_ok) flags_d = fold_cda(ccw_flags_t'(flags_raw));
    if (if_check) flags_d.cc = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  // R4
  wrdc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_blocked && !if_check) |=> $stable(flags_q));

  // R5
  check_clr_chk: assert property (@(posedge clk) disable iff (rst)
    if_check |=> !flags_q.cc);

  // R2
  load_pci_chk: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> (flags_q.pci == $past(flags_raw[0]) && flags_q.skip == $past(flags_raw[1])));
endmodule

// File: rtl/sup_out_ctl.sv
module sup_out_ctl
  import ccw_flag_pkg::*;
#(
  parameter bit CLEAR_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic chan_end,
  input  logic cc_q,
  input  logic load_ok,
  input  logic raw_cda,
  input  logic dir_write,
  input  logic wr_reg_full,
  input  logic rec_end,
  input  logic unit_sel,
  input  logic bytecnt_load,
  output logic sup_q
);
  logic set_cc_end;
  logic set_rd_cda;
  logic set_wr_full;
  logic sup_set;
  logic sup_clr;

  assign set_cc_end  = chan_end && cc_q;
  assign set_rd_cda  = load_ok && !dir_write && raw_cda;
  assign set_wr_full = dir_write && wr_reg_full && !rec_end;
  assign sup_set     = set_cc_end || set_rd_cda || set_wr_full;
  assign sup_clr     = unit_sel || bytecnt_load;

  always_ff @(posedge clk) begin
    if (rst) sup_q <= 1'b0;
    else     sup_q <= latch_next(sup_q, sup_set, sup_clr, CLEAR_WINS);
  end

  // R6
  cc_end_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_cc_end && !sup_clr) |=> sup_q);

  // R8
  wr_full_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_wr_full && !sup_clr) |=> sup_q);

  generate
    if (CLEAR_WINS) begin : g_clr_first
      // R9
      sup_clr_chk: assert property (@(posedge clk) disable iff (rst)
        sup_clr |=> !sup_q);
    end
  endgenerate
endmodule

// File: rtl/svc_hold_ctl.sv
module svc_hold_ctl
  import ccw_flag_pkg::*;
#(
  parameter bit CLEAR_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic unit_sel,
  input  logic status_in,
  input  logic cu_busy,
  input  logic fetch_done,
  output logic hold_q
);
  logic in_sel_q;
  logic sel_close;
  logic hold_set;

  assign sel_close = in_sel_q && status_in;
  assign hold_set  = sel_close && !cu_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sel_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      if (unit_sel)       in_sel_q <= 1'b1;
      else if (status_in) in_sel_q <= 1'b0;
      hold_q <= latch_next(hold_q, hold_set, fetch_done, CLEAR_WINS);
    end
  end

  // R10
  hold_set_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_set && !fetch_done) |=> hold_q);

  // R11
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !hold_set) |=> !hold_q);

  generate
    if (CLEAR_WINS) begin : g_clr_first
      // R12
      hold_clr_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_done |=> !hold_q);
    end
  endgenerate
endmodule

// File: rtl/ccw_flag_ctl.sv
module ccw_flag_ctl
  import ccw_flag_pkg::*;
#(
  parameter bit CLEAR_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        ccw_flags_i,
  input  logic              ccw2_load_i,
  input  logic              dir_write_i,
  input  logic              wr_dchain_i,
  input  logic              if_check_i,
  input  logic              chan_end_i,
  input  logic              bytecnt_load_i,
  input  logic              unit_sel_i,
  input  logic              status_in_i,
  input  logic              cu_busy_i,
  input  logic              wr_reg_full_i,
  input  logic              rec_end_i,
  input  logic              fetch_done_i,
  output logic              flag_cda_o,
  output logic              flag_cc_o,
  output logic              flag_sili_o,
  output logic              flag_skip_o,
  output logic              flag_pci_o,
  output logic              sup_out_o,
  output logic              svc_hold_o
);
  ccw_flags_t flags_q;
  logic       load_ok;

  ccw_flag_reg u_flags (
    .clk       (clk),
    .rst       (rst),
    .flags_raw (ccw_flags_i),
    .load      (ccw2_load_i),
    .dir_write (dir_write_i),
    .wr_dchain (wr_dchain_i),
    .if_check  (if_check_i),
    .flags_q   (flags_q),
    .load_ok   (load_ok)
  );

  sup_out_ctl #(.CLEAR_WINS(CLEAR_WINS)) u_sup (
    .clk          (clk),
    .rst          (rst),
    .chan_end     (chan_end_i),
    .cc_q         (flags_q.cc),
    .load_ok      (load_ok),
    .raw_cda      (ccw_flags_i[FLAG_W-1]),
    .dir_write    (dir_write_i),
    .wr_reg_full  (wr_reg_full_i),
    .rec_end      (rec_end_i),
    .unit_sel     (unit_sel_i),
    .bytecnt_load (bytecnt_load_i),
    .sup_q        (sup_out_o)
  );

  svc_hold_ctl #(.CLEAR_WINS(CLEAR_WINS)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .unit_sel   (unit_sel_i),
    .status_in  (status_in_i),
    .cu_busy    (cu_busy_i),
    .fetch_done (fetch_done_i),
    .hold_q     (svc_hold_o)
  );

  assign flag_cda_o  = flags_q.cda;
  assign flag_cc_o   = flags_q.cc;
  assign flag_sili_o = flags_q.sili;
  assign flag_skip_o = flags_q.skip;
  assign flag_pci_o  = flags_q.pci;

  // R3
  cda_excl_chk: assert property (@(posedge clk) disable iff (rst)
    flag_cda_o |-> (!flag_cc_o && !flag_sili_o));

  // R7
  rd_cda_sup_chk: assert property (@(posedge clk) disable iff (rst)
    (ccw2_load_i && !dir_write_i && ccw_flags_i[4] && !unit_sel_i && !bytecnt_load_i)
      |=> sup_out_o);
endmodule

// File: tb/test_ccw_flag_ctl.sv
module test_ccw_flag_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] fl = '0;
  logic ld = 0, wr = 0, wdc = 0, chk = 0, ce = 0, bcl = 0, us = 0;
  logic st = 0, busy = 0, full = 0, rend = 0, fd = 0;
  logic o_cda, o_cc, o_sili, o_skip, o_pci, o_sup, o_hold;

  int n_run = 0;
  int n_fail = 0;

  logic [4:0] mf = '0;
  logic ms = 0, mh = 0, msel = 0;

  always #5 clk = ~clk;

  ccw_flag_ctl i_ccw_flag_ctl (
    .clk(clk), .rst(rst), .ccw_flags_i(fl), .ccw2_load_i(ld),
    .dir_write_i(wr), .wr_dchain_i(wdc), .if_check_i(chk),
    .chan_end_i(ce), .bytecnt_load_i(bcl), .unit_sel_i(us),
    .status_in_i(st), .cu_busy_i(busy), .wr_reg_full_i(full),
    .rec_end_i(rend), .fetch_done_i(fd),
    .flag_cda_o(o_cda), .flag_cc_o(o_cc), .flag_sili_o(o_sili),
    .flag_skip_o(o_skip), .flag_pci_o(o_pci),
    .sup_out_o(o_sup), .svc_hold_o(o_hold)
  );

  function automatic logic [4:0] expect_flags(input logic [4:0] raw);
    return raw[4] ? {3'b100, raw[1:0]} : raw;
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic acc, sset, sclr, hset;
    logic [4:0] nf;
    acc  = ld && !(wr && wdc);
    nf   = acc ? expect_flags(fl) : mf;
    if (chk) nf[3] = 1'b0;
    sset = (ce && mf[3]) || (acc && !wr && fl[4]) || (wr && full && !rend);
    sclr = us || bcl;
    hset = msel && st && !busy;
    ms   = sclr ? 1'b0 : (sset ? 1'b1 : ms);
    mh   = fd ? 1'b0 : (hset ? 1'b1 : mh);
    msel = us ? 1'b1 : (st ? 1'b0 : msel);
    mf   = nf;
  endtask

  task automatic cyc(input string tf, input string ts, input string th);
    model_step();
    @(posedge clk); #1;
    check(tf, {o_cda, o_cc, o_sili, o_skip, o_pci}, mf);
    check(ts, {4'b0, o_sup}, {4'b0, ms});
    check(th, {4'b0, o_hold}, {4'b0, mh});
  endtask

  task automatic idle();
    ld = 0; chk = 0; ce = 0; bcl = 0; us = 0; st = 0; busy = 0;
    full = 0; rend = 0; fd = 0; wdc = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1 reset", {o_cda, o_cc, o_sili, o_skip, o_pci}, 5'b0);
    check("R1 reset", {3'b0, o_sup, o_hold}, 5'b0);
    rst = 0;
    idle();
    cyc("R1 flags", "R1 sup", "R1 hold");

    // R2 and R3: every field value on a read load
    for (int v = 0; v < 32; v++) begin
      idle(); wr = 0; ld = 1; fl = v[4:0];
      cyc("R2/R3 load", "R7 sup", "R11 hold");
      if (v == 31) check("R3 override", {o_cda, o_cc, o_sili, o_skip, o_pci}, 5'b10011);
      idle(); us = 1;
      cyc("R2 keep", "R9 clear", "R11 hold");
    end

    // R4 blocked load on write with data chaining
    idle(); wr = 0; ld = 1; fl = 5'b01110;
    cyc("R2 load", "R9 sup", "R11 hold");
    idle(); wr = 1; wdc = 1; ld = 1; fl = 5'b10001;
    cyc("R4 ignored", "R8 sup", "R11 hold");
    check("R4 flags kept", {o_cda, o_cc, o_sili, o_skip, o_pci}, 5'b01110);

    // R6 channel end with chain command, then R5 check clear
    idle(); ce = 1;
    cyc("R5 flags", "R6 set", "R11 hold");
    check("R6 sup", {4'b0, o_sup}, 5'b00001);
    idle(); chk = 1;
    cyc("R5 clear", "R9 keep", "R11 hold");
    check("R5 cc cleared", {o_cda, o_cc, o_sili, o_skip, o_pci}, 5'b00110);
    // R5 on a load cycle
    idle(); ld = 1; wr = 0; fl = 5'b01001; chk = 1;
    cyc("R5 load+check", "R9 keep", "R11 hold");
    // R9 clear wins against a set
    idle(); ce = 1; bcl = 1;
    cyc("R5 flags", "R9 clear wins", "R11 hold");
    check("R9 sup", {4'b0, o_sup}, 5'b0);

    // R8 write register full
    idle(); wr = 1; full = 1; rend = 0;
    cyc("R4 flags", "R8 set", "R11 hold");
    idle(); wr = 1; full = 1; rend = 1; bcl = 1;
    cyc("R4 flags", "R9 clear", "R11 hold");

    // R10 selection then status
    idle(); us = 1;
    cyc("R2 flags", "R9 sup", "R11 no status");
    idle(); st = 1;
    cyc("R2 flags", "R9 sup", "R10 set");
    check("R10 hold", {4'b0, o_hold}, 5'b00001);
    idle(); st = 1;
    cyc("R2 flags", "R9 sup", "R12 keep");
    idle(); fd = 1;
    cyc("R2 flags", "R9 sup", "R12 clear");
    // R11 busy status
    idle(); us = 1;
    cyc("R2 flags", "R9 sup", "R11 open");
    idle(); st = 1; busy = 1;
    cyc("R2 flags", "R9 sup", "R11 busy");
    idle(); st = 1;
    cyc("R2 flags", "R9 sup", "R11 outside sel");
    check("R11 hold", {4'b0, o_hold}, 5'b0);
    // R12 clear wins over set
    idle(); us = 1;
    cyc("R2 flags", "R9 sup", "R10 open");
    idle(); st = 1; fd = 1;
    cyc("R2 flags", "R9 sup", "R12 clear wins");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      fl   = 5'($urandom);
      ld   = ($urandom % 4) == 0;
      wr   = $urandom % 2;
      wdc  = ($urandom % 3) == 0;
      chk  = ($urandom % 16) == 0;
      ce   = ($urandom % 8) == 0;
      bcl  = ($urandom % 16) == 0;
      us   = ($urandom % 16) == 0;
      st   = ($urandom % 6) == 0;
      busy = ($urandom % 3) == 0;
      full = ($urandom % 8) == 0;
      rend = $urandom % 2;
      fd   = ($urandom % 10) == 0;
      cyc("R2/R3/R4/R5 flags", "R6/R7/R8/R9 sup", "R10/R11/R12 hold");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule